// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Controller

This block is a watchdog that escalates. It does not reset the system on the first missed deadline. A free-running counter provides the time base. Each rising edge of one selected counter bit produces a one-cycle time-out event. Two status flags, `enable_next` and `irq_status`, form a two-bit escalation state. The first unserviced time-out arms the watchdog. The second posts an interrupt status, which becomes an interrupt when both enable inputs allow it. The third issues a reset request of the kind held in a two-bit reset-control field.

Software services the watchdog by clearing the status flags through a write-one-to-clear port. A routine that clears `enable_next` often enough never sees an exception. An interrupt handler that clears both flags resets the escalation to its start.

When the reset request fires, the kind of reset is copied into a reset-cause field, and the control field returns to zero. Both fields keep their values after the pulse, so the cause can be read afterwards. The processor reset sequencing itself lies outside this block.

Top module: `wdt_ctrl`

## Requirements
- R1: After `rst_n` is released, `enable_next`, `irq_status`, `irq`, `rst_req`, `timeout`, `rst_ctl` and `rst_cause` are all 0.
- R2: `timeout` is a one-cycle pulse that recurs every 2^(TAP_BASE+TAP_STEP*period_sel+1) cycles. With the defaults this is 16 cycles for `period_sel`=0 and 64 cycles for `period_sel`=1.
- R3: A time-out while `enable_next`=0 sets `enable_next` and leaves `irq_status` unchanged. The state {enable_next, irq_status} moves from 00 to 10, or from 01 to 11.
- R4: A time-out in state 10 sets `irq_status`, which moves the state to 11.
- R5: `irq` is 1 exactly when `irq_status`, `irq_en` and `crit_en` are all 1.
- R6: A time-out in state 11 with `rst_ctl` not 00 makes `rst_req` high in the next cycle. It also loads `rst_cause` with the old `rst_ctl` and clears `rst_ctl` to 00. The state bits do not change. With `rst_ctl`=00 the same time-out has no effect.
- R7: `rst_req` is high for exactly one cycle. `rst_cause` and `rst_ctl` keep their values after it.
- R8: A cycle with `sts_clr_we`=1 clears `enable_next` where `sts_clr_data[1]`=1 and clears `irq_status` where `sts_clr_data[0]`=1. Zero bits have no effect. When a time-out falls in the same cycle, the clear is applied first and the time-out then acts on the cleared state.
- R9: Suppose both flags are cleared at a cycle with no time-out, and no further service follows. Then `irq_status` rises more than one and at most two full periods later, counted in clock edges.
- R10: `ctl_we`=1 loads `ctl_wdata` into `rst_ctl`, except in a cycle where a reset request fires; the clear of R6 wins there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_sel | input | 2 | Selects which counter bit defines the period |
| irq_en | input | 1 | Watchdog interrupt enable |
| crit_en | input | 1 | Critical-interrupt enable |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_data | input | 2 | Clear mask: bit 1 `enable_next`, bit 0 `irq_status` |
| ctl_we | input | 1 | Reset-control write strobe |
| ctl_wdata | input | 2 | Reset-control write value |
| timeout | output | 1 | One-cycle time-out event |
| enable_next | output | 1 | Armed flag |
| irq_status | output | 1 | Interrupt-status flag |
| rst_ctl | output | 2 | Reset-control field |
| rst_cause | output | 2 | Captured kind of the last reset request |
| irq | output | 1 | Gated interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A table of clear masks is applied, each in the cycle of a time-out, so that every escalation state meets every kind of clear. The outcomes tell apart clear-then-advance ordering from advance-then-clear ordering. They also separate arming from posting, and a reset request with a non-zero control field from a quiet one with a zero field. Directed cases then toggle each interrupt enable separately and clear the flags at quiet cycles. They measure the service window and the period for two selects, and confirm that the reset cause and the cleared control field persist after a one-cycle request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_POSTD = 2'b01,
    ST_ARMED = 2'b10,
    ST_ESC   = 2'b11
  } wdt_state_e;

  typedef logic [1:0] rst_kind_t;

  localparam int unsigned CLR_NEXT_BIT = 1;
  localparam int unsigned CLR_STS_BIT  = 0;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int unsigned TAP_BASE = 3,
  parameter int unsigned TAP_STEP = 2,
  parameter int unsigned SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             timeout
);
  localparam int unsigned NUM_TAPS = 1 << SEL_W;
  localparam int unsigned CNT_W    = TAP_BASE + TAP_STEP * (NUM_TAPS - 1) + 1;

  logic [CNT_W-1:0]    cnt;
  logic [NUM_TAPS-1:0] taps;
  logic                tap_q;

  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
    assign taps[gi] = cnt[TAP_BASE + TAP_STEP * gi];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt   <= cnt + 1'b1;
      tap_q <= taps[sel];
    end
  end

  assign timeout = taps[sel] & ~tap_q;

  // R2: the event never lasts two cycles
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      timeout,
  input  logic      clr_we,
  input  logic [1:0] clr_data,
  input  logic      ctl_we,
  input  rst_kind_t ctl_wdata,
  output logic      enable_next,
  output logic      irq_status,
  output rst_kind_t rst_ctl,
  output rst_kind_t rst_cause,
  output logic      rst_req
);
  logic       next_c, sts_c;
  logic       next_d, sts_d;
  logic       fire;
  wdt_state_e st_c;

  always_comb begin
    next_c = enable_next & ~(clr_we & clr_data[CLR_NEXT_BIT]);
    sts_c  = irq_status  & ~(clr_we & clr_data[CLR_STS_BIT]);
    st_c   = wdt_state_e'({next_c, sts_c});
    next_d = next_c;
    sts_d  = sts_c;
    fire   = 1'b0;
    if (timeout) begin
      unique case (st_c)
        ST_IDLE, ST_POSTD: next_d = 1'b1;
        ST_ARMED:          sts_d  = 1'b1;
        ST_ESC:            fire   = (rst_ctl != 2'b00);
        default:           ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_next <= 1'b0;
      irq_status  <= 1'b0;
      rst_ctl     <= '0;
      rst_cause   <= '0;
      rst_req     <= 1'b0;
    end else begin
      enable_next <= next_d;
      irq_status  <= sts_d;
      rst_req     <= fire;
      if (fire) begin
        rst_cause <= rst_ctl;
        rst_ctl   <= '0;
      end else if (ctl_we) begin
        rst_ctl <= ctl_wdata;
      end
    end
  end

  // R4: status can only appear from the armed state on an event
  a_r4_post_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status) |-> ($past(enable_next) && $past(timeout)));
  // R6: the cause is the control value from before the request
  a_r6_cause_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_cause == $past(rst_ctl)));
  // R6: the control field is cleared with the request
  a_r6_ctl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_ctl == 2'b00));
  // R7: one-cycle request
  a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R8: flags move only on a clear or an event
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!timeout && !clr_we) |=> $stable({enable_next, irq_status}));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned TAP_BASE = 3,
  parameter int unsigned TAP_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] period_sel,
  input  logic       irq_en,
  input  logic       crit_en,
  input  logic       sts_clr_we,
  input  logic [1:0] sts_clr_data,
  input  logic       ctl_we,
  input  logic [1:0] ctl_wdata,
  output logic       timeout,
  output logic       enable_next,
  output logic       irq_status,
  output logic [1:0] rst_ctl,
  output logic [1:0] rst_cause,
  output logic       irq,
  output logic       rst_req
);
  wdt_timebase #(
    .TAP_BASE(TAP_BASE),
    .TAP_STEP(TAP_STEP),
    .SEL_W   (2)
  ) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (period_sel),
    .timeout(timeout)
  );

  wdt_escalate u_esc (
    .clk        (clk),
    .rst_n      (rst_n),
    .timeout    (timeout),
    .clr_we     (sts_clr_we),
    .clr_data   (sts_clr_data),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .enable_next(enable_next),
    .irq_status (irq_status),
    .rst_ctl    (rst_ctl),
    .rst_cause  (rst_cause),
    .rst_req    (rst_req)
  );

  assign irq = irq_status & irq_en & crit_en;
endmodule

// File: tb/wdt_ctrl_test.sv
module wdt_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int P0 = 16;
  localparam int P1 = 64;
  localparam int WD_LIMIT = 20000;
  // {clear mask[1:0], expected enable_next, expected irq_status, expected rst_req}
  localparam logic [4:0] VEC [10] = '{
    5'b00_10_0, 5'b00_11_0, 5'b00_11_1, 5'b00_11_0, 5'b11_10_0,
    5'b10_10_0, 5'b00_11_0, 5'b01_11_0, 5'b10_11_0, 5'b00_11_0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] period_sel = 2'd0;
  logic irq_en = 1'b1, crit_en = 1'b1;
  logic sts_clr_we = 1'b0, ctl_we = 1'b0;
  logic [1:0] sts_clr_data = 2'd0, ctl_wdata = 2'd0;
  logic timeout, enable_next, irq_status, irq, rst_req;
  logic [1:0] rst_ctl, rst_cause;
  int errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .period_sel(period_sel), .irq_en(irq_en),
    .crit_en(crit_en), .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .timeout(timeout),
    .enable_next(enable_next), .irq_status(irq_status), .rst_ctl(rst_ctl),
    .rst_cause(rst_cause), .irq(irq), .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_timeout();
    @(negedge clk);
    while (!timeout) @(negedge clk);
  endtask

  task automatic clear_quiet(input logic [1:0] m);
    @(negedge clk);
    while (timeout) @(negedge clk);
    sts_clr_we = 1'b1; sts_clr_data = m;
    @(negedge clk);
    sts_clr_we = 1'b0; sts_clr_data = 2'd0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 enable_next", enable_next, 0);
    check("R1 irq_status", irq_status, 0);
    check("R1 rst_ctl", rst_ctl, 0);
    check("R1 rst_cause", rst_cause, 0);
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);
    check("R1 timeout", timeout, 0);

    // R10 control write
    ctl_we = 1'b1; ctl_wdata = 2'b10;
    @(negedge clk);
    ctl_we = 1'b0;
    check("R10 rst_ctl written", rst_ctl, 2);

    // vector walk: R3 R4 R6 R8
    for (int i = 0; i < 10; i++) begin
      wait_timeout();
      sts_clr_we = (VEC[i][4:3] != 2'b00);
      sts_clr_data = VEC[i][4:3];
      @(negedge clk);
      sts_clr_we = 1'b0; sts_clr_data = 2'd0;
      check($sformatf("R3 R4 R8 vec%0d enable_next", i), enable_next, VEC[i][2]);
      check($sformatf("R4 R8 vec%0d irq_status", i), irq_status, VEC[i][1]);
      check($sformatf("R6 vec%0d rst_req", i), rst_req, VEC[i][0]);
    end
    check("R6 R7 cause kept", rst_cause, 2);
    check("R6 R7 ctl cleared", rst_ctl, 0);

    // R5 interrupt gating, state is 11
    @(negedge clk);
    check("R5 both enables", irq, 1);
    crit_en = 1'b0; #1;
    check("R5 crit off", irq, 0);
    crit_en = 1'b1; irq_en = 1'b0; #1;
    check("R5 irq_en off", irq, 0);
    irq_en = 1'b1;

    // R8 quiet clears
    clear_quiet(2'b01);
    check("R8 status cleared", irq_status, 0);
    check("R8 next kept", enable_next, 1);
    check("R5 irq after clear", irq, 0);
    clear_quiet(2'b00);
    check("R8 zero mask no effect", enable_next, 1);
    clear_quiet(2'b10);
    check("R8 next cleared", enable_next, 0);

    // R9 service window
    clear_quiet(2'b11);
    n = 1;
    while (!irq_status) begin
      @(negedge clk);
      n++;
    end
    check("R9 window above one period", int'(n > P0), 1);
    check("R9 window within two periods", int'(n <= 2*P0), 1);

    // R6 R7 reset with kind 01
    ctl_we = 1'b1; ctl_wdata = 2'b01;
    @(negedge clk);
    ctl_we = 1'b0;
    wait_timeout();
    @(negedge clk);
    check("R6 rst_req", rst_req, 1);
    check("R6 cause", rst_cause, 1);
    check("R6 ctl cleared", rst_ctl, 0);
    check("R6 state kept", {enable_next, irq_status}, 3);
    @(negedge clk);
    check("R7 pulse ends", rst_req, 0);
    check("R7 cause persists", rst_cause, 1);

    // R2 periods
    wait_timeout();
    n = 0;
    @(negedge clk);
    check("R2 one-cycle pulse", timeout, 0);
    n = 1;
    while (!timeout) begin @(negedge clk); n++; end
    check("R2 period sel0", n, P0);
    period_sel = 2'd1;
    wait_timeout();
    wait_timeout();
    n = 0;
    do begin @(negedge clk); n++; end while (!timeout);
    check("R2 period sel1", n, P1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule